// File: doc/BRIEF.md
# JTAG Master Shift Sequencer

This block is a host-side JTAG engine for one target device. It generates the test clock from the system clock and drives the mode-select and data-in lines itself. It samples the target's data-out line and runs one of three commands: a TAP reset that parks the controller in Run-Test/Idle, an instruction shift, or a data shift of 1 to 32 bits. Every shift starts from Run-Test/Idle, walks the TAP through a fixed mode-select path into the shift state, and moves the data least significant bit first. It then returns the TAP to Run-Test/Idle and reports the captured bits.

Commands arrive on a valid/ready port. The sequencer runs one command at a time and holds `cmd_ready_o` low from acceptance until its result is posted. An upstream source that keeps `cmd_valid_i` high is stalled with no limit and loses nothing. The result is a one-cycle `rsp_valid_o` strobe with no ready, so the consumer must take it in that cycle. The test clock half-period is `tck_div_i + 1` system cycles. The divider is latched when a command is accepted.

Top module: `jtag_shift_master`

## Requirements
- R1: After reset `tck_o`, `tms_o` and `tdi_o` are low, `cmd_ready_o` is high and `rsp_valid_o` is low.
- R2: Opcode 2'b00 (TAP reset) produces 9 test-clock cycles, with mode-select high on the first eight and low on the ninth. The TAP ends in Run-Test/Idle, and the result reports `rsp_err_o`=0 and `rsp_data_o`=0.
- R3: Opcode 2'b01 (instruction shift) with length N produces N+6 test-clock cycles. Mode-select is 1,1,0,0, then low on the first N-1 shift cycles, high on the Nth, then 1,0. The TAP ends in Run-Test/Idle after one Update-IR.
- R4: Opcode 2'b10 (data shift) with length N produces N+5 test-clock cycles. Mode-select is 1,0,0, then low on the first N-1 shift cycles, high on the Nth, then 1,0. The TAP ends in Run-Test/Idle after one Update-DR.
- R5: During the N shift cycles `tdi_o` carries `cmd_data_i` bit 0 first, then bit 1, and so on up to bit N-1.
- R6: `tdo_i` is sampled on each rising test-clock edge of the shift cycles. The first sample lands in `rsp_data_o` bit 0, and bits N and above are zero.
- R7: The test clock is low and then high for `tck_div_i`+1 system cycles each. `tms_o` and `tdi_o` change only while it is low, never while it is high.
- R8: A command is rejected without any test-clock pulse if it has opcode 2'b11, or a shift opcode with length 0 or above 32. The rejection shows as `rsp_valid_o`=1, `rsp_err_o`=1 and `rsp_data_o`=0 in the cycle after acceptance, and the TAP state is left unchanged.
- R9: `cmd_ready_o` is low from acceptance until the result strobe. `rsp_valid_o` is a single-cycle pulse that follows the final falling test-clock edge, and it only occurs while `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tck_div_i | input | 8 | Test-clock half-period minus one, in system cycles |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command taken when valid is also high |
| cmd_op_i | input | 2 | 00 TAP reset, 01 instruction shift, 10 data shift, 11 invalid |
| cmd_len_i | input | 6 | Shift length in bits, 1 to 32 |
| cmd_data_i | input | 32 | Bits to shift out, LSB first |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| rsp_err_o | output | 1 | Command was rejected |
| rsp_data_o | output | 32 | Captured target bits, first bit in bit 0 |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to target |
| tdo_i | input | 1 | Test data from target |

## Verification
The bench attaches a full sixteen-state TAP model with separate instruction and data registers. Each register returns a distinct capture pattern, so a mix-up between the two paths is visible. Shift lengths of 1, 5, 8, 17 and 32 separate an off-by-one in the final mode-select bit or the result alignment from a correct count. Data words with asymmetric bit patterns expose bit-order reversal on both the driven and the captured side. Illegal lengths and the reserved opcode confirm that nothing toggles on the target lines, and two further divider settings separate a wrong test-clock period from a wrong edge count.

// File: rtl/jtm_pkg.sv
package jtm_pkg;
  typedef enum logic [1:0] {
    OP_TAP_RESET = 2'b00,
    OP_SHIFT_IR  = 2'b01,
    OP_SHIFT_DR  = 2'b10,
    OP_RSVD      = 2'b11
  } jtm_op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_SHIFT,
    PH_POST
  } jtm_phase_e;

  // Mode-select navigation patterns, bit k drives test-clock cycle k.
  localparam logic [8:0] NAV_RESET = 9'b0_1111_1111;
  localparam logic [8:0] NAV_IR    = 9'b0_0000_0011;
  localparam logic [8:0] NAV_DR    = 9'b0_0000_0001;
  localparam logic [3:0] LAST_RESET = 4'd8;
  localparam logic [3:0] LAST_IR    = 4'd3;
  localparam logic [3:0] LAST_DR    = 4'd2;
endpackage

// File: rtl/jtm_tck_gen.sv
module jtm_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_q);
  assign rise_o = wrap && !tck_o;
  assign fall_o = wrap && tck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
      tck_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      div_q <= div_i;
      tck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_o <= ~tck_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jtm_shifter.sv
module jtm_shifter #(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     data_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             tdo_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             tdi_o,
  output logic [W-1:0]     result_o
);
  logic [W-1:0]     out_q;
  logic [W-1:0]     in_q;
  logic [CNT_W-1:0] align;

  assign tdi_o    = out_q[0];
  assign align    = CNT_W'(W) - len_i;
  assign result_o = in_q >> align;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
    end else if (load_i) begin
      out_q <= data_i;
      in_q  <= '0;
    end else begin
      if (shift_i)  out_q <= out_q >> 1;
      if (sample_i) in_q  <= {tdo_i, in_q[W-1:1]};
    end
  end
endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
  import jtm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  tck_div_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  localparam int SLOT_W = (LEN_W > 4) ? LEN_W : 4;

  jtm_phase_e        phase_q;
  jtm_op_e           op_q;
  jtm_op_e           cmd_op;
  logic [LEN_W-1:0]  len_q;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]        nav_q;
  logic [3:0]        pre_last_q;
  logic [8:0]        nav_sel;
  logic [3:0]        last_sel;
  logic              bad, accept, go, rise, fall, sh_tdi;
  logic [DATA_W-1:0] sh_result;

  assign cmd_op      = jtm_op_e'(cmd_op_i);
  assign cmd_ready_o = (phase_q == PH_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign bad         = (cmd_op == OP_RSVD) ||
                       ((cmd_op != OP_TAP_RESET) &&
                        ((cmd_len_i == '0) || (cmd_len_i > LEN_W'(DATA_W))));
  assign go          = accept && !bad;
  assign tdi_o       = (phase_q == PH_SHIFT) ? sh_tdi : 1'b0;

  always_comb begin
    case (cmd_op)
      OP_SHIFT_IR: begin nav_sel = NAV_IR;    last_sel = LAST_IR;    end
      OP_SHIFT_DR: begin nav_sel = NAV_DR;    last_sel = LAST_DR;    end
      default:     begin nav_sel = NAV_RESET; last_sel = LAST_RESET; end
    endcase
  end

  jtm_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go),
    .run_i(phase_q != PH_IDLE), .div_i(tck_div_i),
    .tck_o(tck_o), .rise_o(rise), .fall_o(fall)
  );

  jtm_shifter #(.W(DATA_W), .CNT_W(LEN_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go), .data_i(cmd_data_i),
    .shift_i(fall && (phase_q == PH_SHIFT)),
    .sample_i(rise && (phase_q == PH_SHIFT)),
    .tdo_i(tdo_i), .len_i(len_q), .tdi_o(sh_tdi), .result_o(sh_result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      op_q        <= OP_TAP_RESET;
      len_q       <= '0;
      slot_q      <= '0;
      nav_q       <= '0;
      pre_last_q  <= '0;
      tms_o       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept) begin
        if (bad) begin
          rsp_valid_o <= 1'b1;
          rsp_err_o   <= 1'b1;
          rsp_data_o  <= '0;
        end else begin
          op_q       <= cmd_op;
          len_q      <= cmd_len_i;
          phase_q    <= PH_PRE;
          slot_q     <= '0;
          nav_q      <= nav_sel[8:1];
          pre_last_q <= last_sel;
          tms_o      <= nav_sel[0];
        end
      end else if (fall) begin
        case (phase_q)
          PH_PRE: begin
            if (slot_q == SLOT_W'(pre_last_q)) begin
              if (op_q == OP_TAP_RESET) begin
                phase_q     <= PH_IDLE;
                tms_o       <= 1'b0;
                rsp_valid_o <= 1'b1;
                rsp_err_o   <= 1'b0;
                rsp_data_o  <= '0;
              end else begin
                phase_q <= PH_SHIFT;
                slot_q  <= '0;
                tms_o   <= (len_q == LEN_W'(1));
              end
            end else begin
              slot_q <= slot_q + 1'b1;
              tms_o  <= nav_q[0];
              nav_q  <= nav_q >> 1;
            end
          end
          PH_SHIFT: begin
            if (slot_q == SLOT_W'(len_q) - SLOT_W'(1)) begin
              phase_q <= PH_POST;
              slot_q  <= '0;
              tms_o   <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
              tms_o  <= (slot_q + SLOT_W'(2) == SLOT_W'(len_q));
            end
          end
          PH_POST: begin
            if (slot_q == '0) begin
              slot_q <= SLOT_W'(1);
              tms_o  <= 1'b0;
            end else begin
              phase_q     <= PH_IDLE;
              tms_o       <= 1'b0;
              rsp_valid_o <= 1'b1;
              rsp_err_o   <= 1'b0;
              rsp_data_o  <= sh_result;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_LINES_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o))); // R7

  AST_REJECT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad) |=> (rsp_valid_o && rsp_err_o && !tck_o)); // R8

  AST_READY_TCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !tck_o); // R9

  AST_RSP_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> cmd_ready_o); // R9
endmodule

// File: tb/tb_jtag_shift_master.sv
module tb_jtag_shift_master;
  localparam logic [31:0] IR_CAP = 32'h9C3B_6E15;
  localparam logic [31:0] DR_CAP = 32'hC0DE_5A71;
  localparam int NV = 11;
  // {op[39:38], len[37:32], data[31:0]}
  localparam logic [39:0] VEC [NV] = '{
    {2'b10, 6'd32, 32'h1234_5678},
    {2'b10, 6'd1,  32'hFFFF_FFFF},
    {2'b10, 6'd8,  32'h0000_00A5},
    {2'b01, 6'd5,  32'h0000_001E},
    {2'b01, 6'd5,  32'h0000_001F},
    {2'b10, 6'd17, 32'h0001_5A5A},
    {2'b01, 6'd32, 32'hFFFF_0000},
    {2'b10, 6'd0,  32'h0000_0001},
    {2'b01, 6'd33, 32'h0000_0002},
    {2'b11, 6'd8,  32'h0000_0003},
    {2'b01, 6'd1,  32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  div = 8'd1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_len = 6'd0;
  logic [31:0] cmd_data = 32'h0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic        tck, tms, tdi;
  logic        tdo = 1'b0;

  jtag_shift_master dut (
    .clk_i(clk), .rst_ni(rst_n), .tck_div_i(div),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_len_i(cmd_len), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
  );

  // ---------------- target TAP model ----------------
  typedef enum logic [3:0] {
    T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR, T_UPDDR,
    T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPDIR
  } tap_e;

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      T_RESET: return m ? T_RESET : T_IDLE;
      T_IDLE:  return m ? T_SELDR : T_IDLE;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDDR : T_PAUDR;
      T_PAUDR: return m ? T_EX2DR : T_PAUDR;
      T_EX2DR: return m ? T_UPDDR : T_SHDR;
      T_UPDDR: return m ? T_SELDR : T_IDLE;
      T_SELIR: return m ? T_RESET : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPDIR : T_PAUIR;
      T_PAUIR: return m ? T_EX2IR : T_PAUIR;
      T_EX2IR: return m ? T_UPDIR : T_SHIR;
      default: return m ? T_SELDR : T_IDLE;
    endcase
  endfunction

  tap_e        tap_s = T_PAUIR;
  logic [31:0] dr_sr = '0, ir_sr = '0, upd_dr = '0, upd_ir = '0;
  int          rises = 0, n_upd_dr = 0, n_upd_ir = 0;
  logic        tms_hist [0:4095];

  always @(posedge tck) begin
    tms_hist[rises % 4096] <= tms;
    rises <= rises + 1;
    case (tap_s)
      T_CAPDR: dr_sr <= DR_CAP;
      T_CAPIR: ir_sr <= IR_CAP;
      T_SHDR:  dr_sr <= {tdi, dr_sr[31:1]};
      T_SHIR:  ir_sr <= {tdi, ir_sr[31:1]};
      T_UPDDR: begin upd_dr <= dr_sr; n_upd_dr <= n_upd_dr + 1; end
      T_UPDIR: begin upd_ir <= ir_sr; n_upd_ir <= n_upd_ir + 1; end
      default: ;
    endcase
    tap_s <= tap_next(tap_s, tms);
  end

  always @(negedge tck)
    tdo <= (tap_s == T_SHDR) ? dr_sr[0] : (tap_s == T_SHIR) ? ir_sr[0] : 1'b0;

  // ---------------- checking ----------------
  int errors = 0, checks = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  logic        r_err;
  logic [31:0] r_data;
  int          r_wait, hi_min, hi_max, lo_min, lo_max, hold_viol, busy_ready, pulse_bad;

  task automatic run_cmd(logic [1:0] op, logic [5:0] len, logic [31:0] data);
    logic acc, prev_t, prev_m, prev_d, first;
    int run;
    cmd_op = op; cmd_len = len; cmd_data = data; cmd_valid = 1'b1;
    forever begin
      acc = cmd_ready;
      @(negedge clk);
      if (acc) break;
    end
    cmd_valid = 1'b0;
    r_wait = 0; hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
    hold_viol = 0; busy_ready = 0; pulse_bad = 0;
    prev_t = 1'b0; prev_m = tms; prev_d = tdi; run = 0; first = 1'b1;
    while (!rsp_valid && r_wait < 20000) begin
      if (cmd_ready) busy_ready++;
      if (!first && tck && prev_t && (tms !== prev_m || tdi !== prev_d)) hold_viol++;
      if (tck == prev_t) run++;
      else begin
        if (prev_t) begin hi_min = (run < hi_min) ? run : hi_min; hi_max = (run > hi_max) ? run : hi_max; end
        else        begin lo_min = (run < lo_min) ? run : lo_min; lo_max = (run > lo_max) ? run : lo_max; end
        prev_t = tck; run = 1;
      end
      prev_m = tms; prev_d = tdi; first = 1'b0;
      @(negedge clk);
      r_wait++;
    end
    if (prev_t && run > 0) begin
      hi_min = (run < hi_min) ? run : hi_min; hi_max = (run > hi_max) ? run : hi_max;
    end
    r_err = rsp_err; r_data = rsp_data;
    @(negedge clk);
    if (rsp_valid) pulse_bad++;
  endtask

  task automatic check_tms(string req, int base, int pre, logic [8:0] nav, int n);
    logic [63:0] exp_v, act_v;
    int total;
    exp_v = '0; act_v = '0;
    total = pre + n + 2;
    for (int k = 0; k < pre; k++) exp_v[k] = nav[k];
    exp_v[pre + n - 1] = 1'b1;
    exp_v[pre + n]     = 1'b1;
    for (int k = 0; k < total; k++) act_v[k] = tms_hist[(base + k) % 4096];
    chk(req, "tms sequence", act_v, exp_v);
  endtask

  initial begin
    // R1: reset state
    #20;
    @(negedge clk);
    chk("R1", "tck/tms/tdi/ready/rsp", {59'd0, tck, tms, tdi, cmd_ready, rsp_valid}, 64'b00010);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: TAP reset from an arbitrary state
    begin
      int b; b = rises;
      run_cmd(2'b00, 6'd0, 32'h0);
      chk("R2", "tck cycles", 64'(rises - b), 64'd9);
      begin
        logic [63:0] act_v; act_v = '0;
        for (int k = 0; k < 9; k++) act_v[k] = tms_hist[(b + k) % 4096];
        chk("R2", "tms sequence", act_v, 64'h0FF);
      end
      chk("R2", "tap state", 64'(tap_s), 64'(T_IDLE));
      chk("R2", "err/data", {31'd0, r_err, r_data}, 64'd0);
    end

    // vector table, div = 1
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [5:0] len; logic [31:0] dat;
      int b, bir, bdr, n;
      tap_e s0;
      logic isbad;
      string rq;
      op = VEC[i][39:38]; len = VEC[i][37:32]; dat = VEC[i][31:0];
      n = int'(len);
      b = rises; bir = n_upd_ir; bdr = n_upd_dr; s0 = tap_s;
      isbad = (op == 2'b11) || (n == 0) || (n > 32);
      run_cmd(op, len, dat);
      if (isbad) begin
        chk("R8", "err flag", 64'(r_err), 64'd1);
        chk("R8", "data", 64'(r_data), 64'd0);
        chk("R8", "result delay", 64'(r_wait), 64'd0);
        chk("R8", "tck pulses", 64'(rises - b), 64'd0);
        chk("R8", "tap untouched", 64'(tap_s), 64'(s0));
      end else begin
        rq = (op == 2'b01) ? "R3" : "R4";
        chk(rq, "err flag", 64'(r_err), 64'd0);
        chk(rq, "tck cycles", 64'(rises - b), 64'(n + ((op == 2'b01) ? 6 : 5)));
        chk(rq, "tap idle", 64'(tap_s), 64'(T_IDLE));
        if (op == 2'b01) begin
          check_tms("R3", b, 4, 9'h003, n);
          chk("R3", "update-ir count", 64'(n_upd_ir - bir), 64'd1);
          chk("R5", "tdi bits ir", 64'(upd_ir >> (32 - n)), 64'(dat & lmask(n)));
          chk("R6", "tdo result ir", 64'(r_data), 64'(IR_CAP & lmask(n)));
        end else begin
          check_tms("R4", b, 3, 9'h001, n);
          chk("R4", "update-dr count", 64'(n_upd_dr - bdr), 64'd1);
          chk("R5", "tdi bits dr", 64'(upd_dr >> (32 - n)), 64'(dat & lmask(n)));
          chk("R6", "tdo result dr", 64'(r_data), 64'(DR_CAP & lmask(n)));
        end
        chk("R7", "half periods", {hi_min[15:0], hi_max[15:0], lo_min[15:0], lo_max[15:0]},
            {16'd2, 16'd2, 16'd2, 16'd2});
        chk("R7", "tms/tdi hold while high", 64'(hold_viol), 64'd0);
        chk("R9", "ready low while busy", 64'(busy_ready), 64'd0);
      end
      chk("R9", "single-cycle result", 64'(pulse_bad), 64'd0);
    end

    // R7: other divider settings
    for (int d = 0; d < 2; d++) begin
      int b;
      div = (d == 0) ? 8'd0 : 8'd3;
      b = rises;
      run_cmd(2'b10, 6'd8, 32'h0000_0036);
      chk("R7", "high width", {hi_min[31:0], hi_max[31:0]}, {32'(int'(div) + 1), 32'(int'(div) + 1)});
      chk("R7", "low width", {lo_min[31:0], lo_max[31:0]}, {32'(int'(div) + 1), 32'(int'(div) + 1)});
      chk("R4", "cycles at divider", 64'(rises - b), 64'd13);
      chk("R6", "result at divider", 64'(r_data), 64'(DR_CAP & 32'hFF));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule